// File: doc/BRIEF.md
# Per-Channel Trigger Gate Qualifier

This block sits between the fast-trigger generators of a multi-channel acquisition front end and the event recorder. Each channel produces a one-cycle trigger strobe. At that moment the block decides whether the event is kept or thrown away. The decision looks at two level-sensitive gates: one gate belonging to that channel only, and one gate shared by the whole module. Each gate can either block triggers while it is high (veto sense) or admit triggers only while it is high (validate sense). Software picks the sense of the channel gates and the sense of the module gate independently.

The gate inputs arrive asynchronously, so they pass through a multi-flop synchronizer. The decision uses the synchronized level present on the trigger cycle. For every trigger the block returns a one-cycle accept strobe or a one-cycle reject strobe on that channel. Triggers on several channels in the same cycle are judged separately. A per-channel bypass bit turns gate checking off for a channel, so every trigger on it is accepted.

Software reaches two registers through a small synchronous port. The control register is at address 0: bit 0 is the channel-gate sense and bit 1 is the module-gate sense, where 0 means veto and 1 means validate. Its other bits are stored and read back but have no effect. The bypass mask is at address 1, with bit n covering channel n.

Top module: `trig_gate_qual`

## Requirements
- R1: After reset, accept_o and reject_o are all zero, and the control register (address 0) and the bypass mask (address 1) both read 0. This means veto sense for both gates and no bypass.
- R2: With control bit 0 = 0 (channel veto), a trigger on channel n is rejected if the synchronized channel gate n is high, and accepted if it is low (module gate passing).
- R3: With control bit 0 = 1 (channel validate), a trigger on channel n is accepted only if the synchronized channel gate n is high (module gate passing).
- R4: Control bit 1 selects the module-gate sense in the same way (0 veto, 1 validate), and the module gate applies to every channel's trigger.
- R5: When bypass is clear, a trigger is accepted only if both the channel-gate check and the module-gate check pass; otherwise it is rejected.
- R6: When bypass mask bit n (address 1) is 1, every trigger on channel n is accepted, whatever the gate levels and senses.
- R7: For a trigger sampled at a clock edge, exactly one of accept_o[n] or reject_o[n] is high for the single cycle after that edge. Both are low in cycles without a trigger.
- R8: Triggers on several channels in the same cycle each produce their own outcome, with no effect on one another.
- R9: A gate level applied before clock edge k is first used by a trigger sampled at edge k+2. Triggers sampled at edges k and k+1 still see the previous level.
- R10: Channel gate n affects only channel n's outcome.
- R11: cfg_rdata returns the register selected by cfg_addr. Addresses 2 and 3 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NUM_CH | One-cycle fast-trigger strobe per channel |
| ch_gate_i | input | NUM_CH | Asynchronous per-channel gate levels |
| mod_gate_i | input | 1 | Asynchronous module-wide gate level |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 control, 1 bypass mask) |
| cfg_wdata | input | NUM_CH | Register write data |
| cfg_rdata | output | NUM_CH | Read data of the addressed register |
| accept_o | output | NUM_CH | One-cycle accept strobe per channel |
| reject_o | output | NUM_CH | One-cycle reject strobe per channel |

## Verification
The outcome strobe is due one cycle after the edge that samples a trigger. A gate level takes two more edges to reach the decision, and a register write takes effect from the edge after the write. The bench drives every input on the falling clock edge and reads the outputs on the next falling edge. Before each trigger it waits at least three cycles after changing gates or registers, so that only the settled state is judged. A dedicated sequence then asserts triggers on three consecutive edges right after a gate change, and expects the old, old and new gate level in turn.

// File: rtl/tgq_pkg.sv
package tgq_pkg;

    localparam int CFG_ADDR_W = 2;

    localparam logic [CFG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [CFG_ADDR_W-1:0] ADDR_MASK = 2'd1;

    localparam int CTRL_CH_SENSE_BIT  = 0;
    localparam int CTRL_MOD_SENSE_BIT = 1;

    typedef enum logic {
        SENSE_VETO     = 1'b0,
        SENSE_VALIDATE = 1'b1
    } gate_sense_e;

endpackage

// File: rtl/tgq_sync.sv
module tgq_sync #(
    parameter int WIDTH  = 17,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/tgq_cfg.sv
module tgq_cfg
    import tgq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CFG_ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0]     wdata,
    output logic [NUM_CH-1:0]     rdata,
    output gate_sense_e           ch_sense,
    output gate_sense_e           mod_sense,
    output logic [NUM_CH-1:0]     bypass
);

    typedef struct packed {
        logic [NUM_CH-1:0] ctrl;
        logic [NUM_CH-1:0] mask;
    } cfg_regs_t;

    cfg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: regs_d.ctrl = wdata;
                ADDR_MASK: regs_d.mask = wdata;
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = regs_q.ctrl;
            ADDR_MASK: rdata = regs_q.mask;
            default:   rdata = '0;
        endcase
    end

    assign ch_sense  = gate_sense_e'(regs_q.ctrl[CTRL_CH_SENSE_BIT]);
    assign mod_sense = gate_sense_e'(regs_q.ctrl[CTRL_MOD_SENSE_BIT]);
    assign bypass    = regs_q.mask;

endmodule

// File: rtl/tgq_judge.sv
module tgq_judge
    import tgq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CH-1:0] trig,
    input  logic [NUM_CH-1:0] ch_gate,
    input  logic              mod_gate,
    input  gate_sense_e       ch_sense,
    input  gate_sense_e       mod_sense,
    input  logic [NUM_CH-1:0] bypass,
    output logic [NUM_CH-1:0] accept,
    output logic [NUM_CH-1:0] reject
);

    logic mod_pass;

    // validate: pass while gate high; veto: pass while gate low
    assign mod_pass = (mod_sense == SENSE_VALIDATE) ? mod_gate : ~mod_gate;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ch_pass;
        logic keep;

        assign ch_pass = (ch_sense == SENSE_VALIDATE) ? ch_gate[i] : ~ch_gate[i];
        assign keep    = bypass[i] | (ch_pass & mod_pass);
        assign accept[i] = trig[i] & keep;
        assign reject[i] = trig[i] & ~keep;
    end

endmodule

// File: rtl/trig_gate_qual.sv
module trig_gate_qual
    import tgq_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     trig_i,
    input  logic [NUM_CH-1:0]     ch_gate_i,
    input  logic                  mod_gate_i,
    input  logic                  cfg_wr_en,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [NUM_CH-1:0]     cfg_wdata,
    output logic [NUM_CH-1:0]     cfg_rdata,
    output logic [NUM_CH-1:0]     accept_o,
    output logic [NUM_CH-1:0]     reject_o
);

    localparam int SYNC_W = NUM_CH + 1;

    typedef struct packed {
        logic [NUM_CH-1:0] accept;
        logic [NUM_CH-1:0] reject;
    } outcome_t;

    logic [SYNC_W-1:0] gate_sync;
    gate_sense_e       ch_sense;
    gate_sense_e       mod_sense;
    logic [NUM_CH-1:0] bypass_mask;
    logic [NUM_CH-1:0] acc_comb, rej_comb;
    outcome_t          out_d, out_q;

    tgq_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({mod_gate_i, ch_gate_i}),
        .sync_o  (gate_sync)
    );

    tgq_cfg #(
        .NUM_CH (NUM_CH)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .ch_sense  (ch_sense),
        .mod_sense (mod_sense),
        .bypass    (bypass_mask)
    );

    tgq_judge #(
        .NUM_CH (NUM_CH)
    ) u_judge (
        .trig      (trig_i),
        .ch_gate   (gate_sync[NUM_CH-1:0]),
        .mod_gate  (gate_sync[NUM_CH]),
        .ch_sense  (ch_sense),
        .mod_sense (mod_sense),
        .bypass    (bypass_mask),
        .accept    (acc_comb),
        .reject    (rej_comb)
    );

    always_comb begin
        out_d.accept = acc_comb;
        out_d.reject = rej_comb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign accept_o = out_q.accept;
    assign reject_o = out_q.reject;

endmodule

// File: rtl/tgq_checker.sv
module tgq_checker #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] trig,
    input logic [NUM_CH-1:0] acc,
    input logic [NUM_CH-1:0] rej,
    input logic [NUM_CH-1:0] mask
);

    // R7: each trigger yields an outcome on the next cycle, none without one
    p_outcome_follows_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((acc | rej) == $past(trig)));

    // R7: accept and reject never together on a channel
    p_exclusive_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc & rej) == '0));

    // R6: bypassed channels always accept
    p_bypass_accepts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig & mask) != '0) |=> ((acc & $past(trig & mask)) == $past(trig & mask)));

    // R6: bypassed channels never reject
    p_bypass_no_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig & mask) != '0) |=> ((rej & $past(trig & mask)) == '0));

    // R7: strobes last a single cycle when triggers do not repeat
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == '0) |=> (acc == '0 && rej == '0));

endmodule

bind trig_gate_qual tgq_checker #(.NUM_CH(NUM_CH)) u_tgq_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (trig_i),
    .acc   (accept_o),
    .rej   (reject_o),
    .mask  (bypass_mask)
);

// File: tb/trig_gate_qual_test.sv
module trig_gate_qual_test;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] trig_i;
    logic [N-1:0] ch_gate_i;
    logic         mod_gate_i;
    logic         cfg_wr_en;
    logic [1:0]   cfg_addr;
    logic [N-1:0] cfg_wdata;
    logic [N-1:0] cfg_rdata;
    logic [N-1:0] accept_o;
    logic [N-1:0] reject_o;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    trig_gate_qual uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .ch_gate_i  (ch_gate_i),
        .mod_gate_i (mod_gate_i),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .accept_o   (accept_o),
        .reject_o   (reject_o)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_accept(input logic cs, input logic ms,
                                                input logic [N-1:0] g, input logic m,
                                                input logic [N-1:0] byp, input logic [N-1:0] t);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic cp, mp;
            cp = cs ? g[i] : !g[i];
            mp = ms ? m : !m;
            r[i] = t[i] && (byp[i] || (cp && mp));
        end
        return r;
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_addr  = 2'd0;
    endtask

    task automatic cfg_read(input string req, input logic [1:0] a, input logic [N-1:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // pulse trigger on one edge, outputs read on following negedge
    task automatic fire(input logic [N-1:0] t, output logic [N-1:0] acc, output logic [N-1:0] rej);
        @(negedge clk);
        trig_i = t;
        @(negedge clk);
        trig_i = '0;
        acc = accept_o;
        rej = reject_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] pats [4];
        logic [N-1:0] masks [3];
        logic [N-1:0] a, r;

        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h0F0F;
        masks[0] = 16'h0000; masks[1] = 16'h00FF; masks[2] = 16'h8001;

        rst_n = 1'b0; trig_i = '0; ch_gate_i = '0; mod_gate_i = 1'b0;
        cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 accept", accept_o, '0);
        check("R1 reject", reject_o, '0);
        cfg_read("R1 ctrl", 2'd0, '0);
        cfg_read("R1 mask", 2'd1, '0);

        // R11: register access
        cfg_write(2'd0, 16'hBEE0);
        cfg_read("R11 ctrl readback", 2'd0, 16'hBEE0);
        cfg_write(2'd2, 16'h1234);
        cfg_write(2'd3, 16'h5678);
        cfg_read("R11 unmapped 2", 2'd2, '0);
        cfg_read("R11 unmapped 3", 2'd3, '0);
        cfg_read("R11 ctrl untouched", 2'd0, 16'hBEE0);
        cfg_read("R11 mask untouched", 2'd1, '0);

        // R2 R3 R4 R5 R6 R8 R10: sweep of senses, masks, module gate, channel patterns
        for (int cs = 0; cs < 2; cs++) begin
            for (int ms = 0; ms < 2; ms++) begin
                cfg_write(2'd0, N'((ms << 1) | cs));
                for (int k = 0; k < 3; k++) begin
                    cfg_write(2'd1, masks[k]);
                    for (int mg = 0; mg < 2; mg++) begin
                        for (int p = 0; p < 4; p++) begin
                            logic [N-1:0] t;
                            logic [N-1:0] ea;
                            t = (p[0]) ? 16'h5A3C : 16'hFFFF;
                            @(negedge clk);
                            ch_gate_i  = pats[p];
                            mod_gate_i = mg[0];
                            repeat (3) @(negedge clk);
                            fire(t, a, r);
                            ea = exp_accept(cs[0], ms[0], pats[p], mg[0], masks[k], t);
                            // R2/R3 channel sense, R4 module sense, R5 both, R6 bypass, R8/R10 per channel
                            check("R5 R2 R3 R4 R6 R8 R10 accept", a, ea);
                            check("R5 R2 R3 R4 R6 R8 R10 reject", r, t & ~ea);
                            @(negedge clk);
                            check("R7 single cycle", accept_o | reject_o, '0);
                        end
                    end
                end
            end
        end

        // R10: one channel's gate affects only that channel (veto, no bypass)
        cfg_write(2'd0, '0);
        cfg_write(2'd1, '0);
        @(negedge clk);
        ch_gate_i = 16'h0010; mod_gate_i = 1'b0;
        repeat (3) @(negedge clk);
        fire(16'hFFFF, a, r);
        check("R10 isolated reject", r, 16'h0010);
        check("R10 others accept", a, 16'hFFEF);

        // R9: gate sync latency, triggers at edges k, k+1, k+2 after change
        @(negedge clk);
        ch_gate_i = '0;
        repeat (3) @(negedge clk);
        ch_gate_i = 16'h0001;
        trig_i    = 16'h0001;
        @(negedge clk);
        check("R9 edge k old level", accept_o, 16'h0001);
        @(negedge clk);
        check("R9 edge k+1 old level", accept_o, 16'h0001);
        @(negedge clk);
        trig_i = '0;
        check("R9 edge k+2 new level", reject_o, 16'h0001);
        check("R9 edge k+2 no accept", accept_o, '0);

        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule